// File: doc/BRIEF.md
# I2C Remote Eight-Bit Port Expander

This block is an I2C slave that gives a host eight general-purpose pins over a two-wire bus. A write transfer carries one or more bytes; each acknowledged byte is latched onto the port. A read transfer returns the levels currently present on the pins, most significant bit first. The pins are quasi-bidirectional. A latched zero turns on a strong pull-down. A latched one leaves the pin to a weak pull-up, and a short strong pull-up pulse is given when the bit goes from zero to one. Any pin latched at one can therefore also be used as an input.

An active-low, open-drain interrupt tells the host that an input has changed, so the host does not have to poll the bus. The interrupt is cleared by a bus access or by the pins returning to their reference value. SDA and SCL arrive from the pads and are sampled with the system clock. Three address pins set the low bits of the slave address, so eight of these blocks can share one bus.

Top module: `rio8_expander`

## Requirements
- R1: Only a start condition (SDA falling while SCL is high) begins a transfer, and a stop condition (SDA rising while SCL is high) ends it. Clocking an address byte without a preceding start gets no acknowledge and does not change the port.
- R2: Received bits are taken while SCL is high, and the slave changes its SDA pull-down only while SCL is low.
- R3: The seven-bit address is binary 0100 followed by the address pins, MSB first, and then a R/W bit where 1 means read. On a match the slave pulls SDA low throughout the ninth clock. On a mismatch it does not acknowledge, ignores the bytes that follow until the next start, and never pulls SDA while idle.
- R4: In a write transfer every data byte is acknowledged and latched onto the port at its ninth clock, and any number of bytes may follow one address.
- R5: Bit n of the latch controls pin n. A latched 0 asserts that pin's pull-down, and a latched 1 releases it. After reset the latch holds all ones.
- R6: A write asserts the strong-pull-up enable for exactly one system clock, only on the bits that go from 0 to 1, and never on a pin that is being pulled down.
- R7: In a read, the synchronised pin levels are captured at the address acknowledge clock and shifted out MSB first. After each master acknowledge the pins are captured again for the next byte. A pin latched at 0 reads as 0.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and does not pull it again until the next start.
- R9: The interrupt output is asserted while any pin latched at 1 differs from its reference level. The reference is taken at each read capture and at each write acknowledge, and a bit newly released by a write is expected to read 1. The interrupt drops once the pins return to the reference or once such an access happens. Pins latched at 0 never raise it.
- R10: A start inside a transfer (a repeated start) restarts address reception, whatever the state of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| dev_sel_i | input | 3 | Hardware address pins, low three address bits |
| pin_i | input | 8 | Levels present on port pins P0..P7 |
| sda_pull_o | output | 1 | 1 turns on the SDA pull-down |
| pin_pull_dn_o | output | 8 | Per-pin strong pull-down enable |
| pin_boost_o | output | 8 | Per-pin one-clock strong pull-up enable |
| irq_pull_o | output | 1 | 1 pulls the active-low interrupt line |

## Verification
Writes use three data patterns. A pattern from all ones with no rising bits checks the pull-downs with no boost pulse. A second byte in the same transfer that releases two bits checks that the boost pulse lands on exactly those bits and lasts one clock. A later write that releases only the top bit checks it again. Reads use a pin pattern that differs from the one presented before the master acknowledge, which tells a single capture at the address apart from a recapture per byte. A read with the upper nibble latched low checks that forced pins read as zero. Address handling is tried with a wrong address, with a correct address clocked without a start, and with a wrong address rescued by a repeated start, which separates address matching from start detection. For the interrupt, input toggles on released and forced pins tell the input mask apart from the plain compare, and the clear is checked both by a read and by a write that matches the pins.

// File: rtl/rio_pkg.sv
package rio_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned CNT_W  = 4;
  localparam logic [3:0]  DEV_ID = 4'b0100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } bus_state_e;

  // Address byte (7 address bits then R/W) matches this device
  function automatic logic addr_hit(input logic [7:0] rx, input logic [2:0] sel);
    return rx[7:1] == {DEV_ID, sel};
  endfunction

  // Bits that go from latched 0 to latched 1
  function automatic logic [PORT_W-1:0] rise_mask(input logic [PORT_W-1:0] old_v,
                                                  input logic [PORT_W-1:0] new_v);
    return new_v & ~old_v;
  endfunction

  // Reference after a write: pins already released keep their level, newly released expect 1
  function automatic logic [PORT_W-1:0] write_ref(input logic [PORT_W-1:0] pins,
                                                  input logic [PORT_W-1:0] old_latch);
    return (pins & old_latch) | ~old_latch;
  endfunction

  // Input change on any released pin
  function automatic logic change_seen(input logic [PORT_W-1:0] pins,
                                       input logic [PORT_W-1:0] ref_v,
                                       input logic [PORT_W-1:0] latch);
    return |((pins ^ ref_v) & latch);
  endfunction
endpackage

// File: rtl/rio_line_sync.sv
module rio_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_d     <= scl_s;
      sda_d     <= sda_s;
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/rio_bus_engine.sv
module rio_bus_engine
  import rio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [2:0]        dev_sel,
  input  logic [PORT_W-1:0] rd_data,
  output logic              sda_pull,
  output logic              wr_evt,
  output logic [PORT_W-1:0] wr_data,
  output logic              rd_cap,
  output bus_state_e        state
);
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(7);

  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        rx_q;
  logic [PORT_W-1:0] tx_q;
  logic              rw_q;

  assign rd_cap  = scl_rise & (((state == ST_AACK) & rw_q) | ((state == ST_RACK) & ~sda_s));
  assign wr_evt  = scl_rise & (state == ST_WACK);
  assign wr_data = rx_q;
  assign sda_pull = (state == ST_AACK) | (state == ST_WACK) | ((state == ST_RDAT) & ~tx_q[PORT_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '1;
      rw_q  <= 1'b0;
    end else if (start_evt) begin
      state <= ST_ADDR;
      cnt_q <= '0;
    end else if (stop_evt) begin
      state <= ST_IDLE;
    end else begin
      if (rd_cap) tx_q <= rd_data;
      unique case (state)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise && cnt_q != BYTE_BITS) begin
            rx_q  <= {rx_q[6:0], sda_s};
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == BYTE_BITS) begin
            if (state == ST_WDAT) begin
              state <= ST_WACK;
            end else if (addr_hit(rx_q, dev_sel)) begin
              state <= ST_AACK;
              rw_q  <= rx_q[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          state <= rw_q ? ST_RDAT : ST_WDAT;
          cnt_q <= '0;
        end
        ST_WACK: if (scl_fall) begin
          state <= ST_WDAT;
          cnt_q <= '0;
        end
        ST_RDAT: if (scl_fall) begin
          if (cnt_q == LAST_BIT) begin
            state <= ST_RACK;
          end else begin
            tx_q  <= {tx_q[PORT_W-2:0], 1'b1};
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_s) state <= ST_IDLE;
          else if (scl_fall) begin
            state <= ST_RDAT;
            cnt_q <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rio_port.sv
module rio_port
  import rio_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_i,
  input  logic              wr_evt,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              rd_cap,
  output logic [PORT_W-1:0] pin_s,
  output logic [PORT_W-1:0] pull_dn,
  output logic [PORT_W-1:0] boost,
  output logic              irq
);
  logic [PORT_W-1:0] sync_q [STAGES];
  logic [PORT_W-1:0] latch_q, ref_q, boost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) sync_q[i] <= '1;
    end else begin
      sync_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end
  assign pin_s = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      ref_q   <= '1;
      boost_q <= '0;
    end else if (wr_evt) begin
      latch_q <= wr_data;
      boost_q <= rise_mask(latch_q, wr_data);
      ref_q   <= write_ref(pin_s, latch_q);
    end else begin
      boost_q <= '0;
      if (rd_cap) ref_q <= pin_s;
    end
  end

  assign pull_dn = ~latch_q;
  assign boost   = boost_q;
  assign irq     = change_seen(pin_s, ref_q, latch_q);
endmodule

// File: rtl/rio8_expander.sv
module rio8_expander
  import rio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        dev_sel_i,
  input  logic [PORT_W-1:0] pin_i,
  output logic              sda_pull_o,
  output logic [PORT_W-1:0] pin_pull_dn_o,
  output logic [PORT_W-1:0] pin_boost_o,
  output logic              irq_pull_o
);
  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_evt, rd_cap;
  logic [PORT_W-1:0] wr_data, pin_s;
  bus_state_e        state_w;

  rio_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .sda_s, .scl_rise, .scl_fall, .start_evt, .stop_evt
  );

  rio_bus_engine u_engine (
    .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_evt, .stop_evt,
    .dev_sel (dev_sel_i),
    .rd_data (pin_s),
    .sda_pull(sda_pull_o),
    .wr_evt, .wr_data, .rd_cap,
    .state   (state_w)
  );

  rio_port #(.STAGES(SYNC_STAGES)) u_port (
    .clk, .rst_n, .pin_i, .wr_evt, .wr_data, .rd_cap, .pin_s,
    .pull_dn(pin_pull_dn_o),
    .boost  (pin_boost_o),
    .irq    (irq_pull_o)
  );
endmodule

// File: rtl/rio8_expander_chk.sv
module rio8_expander_chk
  import rio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_rise,
  input logic              scl_fall,
  input bus_state_e        state,
  input logic              rd_cap,
  input logic [PORT_W-1:0] pin_s,
  input logic              sda_pull,
  input logic [PORT_W-1:0] pull_dn,
  input logic [PORT_W-1:0] boost,
  input logic              irq
);
  logic scl_hi;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scl_hi <= 1'b1;
    else if (scl_rise) scl_hi <= 1'b1;
    else if (scl_fall) scl_hi <= 1'b0;
  end

  assert_boost_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|boost) |=> (boost == '0));

  assert_boost_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|boost) |-> ((boost & pull_dn) == '0));

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |=> (!irq || (pin_s != $past(pin_s))));

  assert_sda_quiet_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull);

  assert_sda_moves_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_hi);
endmodule

bind rio8_expander rio8_expander_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_rise (scl_rise),
  .scl_fall (scl_fall),
  .state    (state_w),
  .rd_cap   (rd_cap),
  .pin_s    (pin_s),
  .sda_pull (sda_pull_o),
  .pull_dn  (pin_pull_dn_o),
  .boost    (pin_boost_o),
  .irq      (irq_pull_o)
);

// File: tb/rio8_expander_tb.sv
module rio8_expander_tb;
  localparam int Q = 8;
  localparam logic [7:0] AW = 8'h4A;  // 0100 101 + write
  localparam logic [7:0] AR = 8'h4B;  // 0100 101 + read

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] ext_pins = 8'hFF;
  logic sda_pull_o, irq_pull_o;
  logic [7:0] pin_pull_dn_o, pin_boost_o, pin_i;
  logic sda_line;
  int tests = 0, fails = 0;
  int boost_cnt = 0;
  logic [7:0] boost_last = 8'h00;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_o;
  assign pin_i    = ext_pins & ~pin_pull_dn_o;

  rio8_expander u_dut (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_line), .dev_sel_i(3'b101),
    .pin_i, .sda_pull_o, .pin_pull_dn_o, .pin_boost_o, .irq_pull_o
  );

  always @(posedge clk) if (pin_boost_o != 8'h00) begin
    boost_cnt  <= boost_cnt + 1;
    boost_last <= pin_boost_o;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
    s = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin clock_bit(1'b1, s); d = {d[6:0], s}; end
  endtask

  task automatic write_one(input logic [7:0] d);
    logic a;
    bus_start; send_byte(AW, a); send_byte(d, a); bus_stop;
  endtask

  task automatic read_one(output logic [7:0] d);
    logic a, s;
    bus_start; send_byte(AR, a); recv_byte(d); clock_bit(1'b1, s); bus_stop;
  endtask

  task automatic t_reset;
    check("R5", "reset pull-down", pin_pull_dn_o, 8'h00);
    check("R6", "reset boost", pin_boost_o, 8'h00);
    check("R3", "reset sda pull", sda_pull_o, 1'b0);
    check("R9", "reset irq", irq_pull_o, 1'b0);
  endtask

  task automatic t_write;
    logic a; int b0;
    bus_start;
    send_byte(AW, a); check("R3", "write address ack", a, 1'b1);
    b0 = boost_cnt;
    send_byte(8'h5A, a); check("R4", "data ack 1", a, 1'b1);
    check("R5", "pull-down after 5A (R2 bits on SCL high)", pin_pull_dn_o, 8'hA5);
    check("R6", "no boost FF->5A", boost_cnt - b0, 0);
    b0 = boost_cnt;
    send_byte(8'h0F, a); check("R4", "data ack 2", a, 1'b1);
    check("R4", "second byte latched", pin_pull_dn_o, 8'hF0);
    check("R6", "boost cycles 5A->0F", boost_cnt - b0, 1);
    check("R6", "boost bits 5A->0F", boost_last, 8'h05);
    bus_stop;
    check("R3", "sda released after stop", sda_pull_o, 1'b0);
  endtask

  task automatic t_wrong_addr;
    logic a;
    bus_start;
    send_byte(8'h46, a); check("R3", "wrong address nack", a, 1'b0);
    send_byte(8'h00, a); check("R3", "byte after mismatch nack", a, 1'b0);
    bus_stop;
    check("R3", "port unchanged after mismatch", pin_pull_dn_o, 8'hF0);
  endtask

  task automatic t_no_start;
    logic a;
    scl_m = 1'b0; tick(Q);
    send_byte(AW, a); check("R1", "no ack without start", a, 1'b0);
    send_byte(8'hFF, a); check("R1", "no data ack without start", a, 1'b0);
    bus_stop;
    check("R1", "port unchanged without start", pin_pull_dn_o, 8'hF0);
  endtask

  task automatic t_read;
    logic a, s, any_low; logic [7:0] d;
    ext_pins = 8'hC3; tick(Q);
    read_one(d); check("R7", "forced pins read low", d, 8'h03);
    write_one(8'hFF);
    bus_start;
    send_byte(AR, a); check("R3", "read address ack", a, 1'b1);
    recv_byte(d); check("R7", "first read byte", d, 8'hC3);
    ext_pins = 8'h3C; tick(Q);
    clock_bit(1'b0, s);
    recv_byte(d); check("R7", "recapture after master ack", d, 8'h3C);
    clock_bit(1'b1, s);
    any_low = 1'b0;
    for (int i = 0; i < 8; i++) begin clock_bit(1'b1, s); any_low |= ~s; end
    check("R8", "sda released after master nack", any_low, 1'b0);
    bus_stop;
  endtask

  task automatic t_irq;
    logic [7:0] d; int b0;
    check("R9", "irq idle after read", irq_pull_o, 1'b0);
    ext_pins = 8'h3D; tick(6); check("R9", "irq on input change", irq_pull_o, 1'b1);
    ext_pins = 8'h3C; tick(6); check("R9", "irq drops on return", irq_pull_o, 1'b0);
    ext_pins = 8'hBC; tick(6); check("R9", "irq on bit7 rise", irq_pull_o, 1'b1);
    read_one(d); check("R7", "read of BC", d, 8'hBC);
    check("R9", "irq cleared by read", irq_pull_o, 1'b0);
    write_one(8'h7F); tick(6);
    check("R9", "forced pin raises no irq", irq_pull_o, 1'b0);
    ext_pins = 8'h3C; tick(6);
    check("R9", "change on forced pin ignored", irq_pull_o, 1'b0);
    ext_pins = 8'hBC; tick(6);
    b0 = boost_cnt;
    write_one(8'hFF); tick(6);
    check("R9", "released pin meets reference", irq_pull_o, 1'b0);
    check("R6", "boost bit7 cycles", boost_cnt - b0, 1);
    check("R6", "boost bit7", boost_last, 8'h80);
    ext_pins = 8'hBD; tick(6); check("R9", "irq before write", irq_pull_o, 1'b1);
    write_one(8'hFF); tick(2);
    check("R9", "irq cleared by write", irq_pull_o, 1'b0);
  endtask

  task automatic t_rstart;
    logic a, s; logic [7:0] d;
    bus_start;
    send_byte(8'h46, a); check("R10", "wrong address before restart", a, 1'b0);
    bus_start;
    send_byte(AW, a); check("R10", "ack after repeated start", a, 1'b1);
    send_byte(8'h81, a); check("R10", "data ack after restart", a, 1'b1);
    bus_start;
    send_byte(AR, a); check("R10", "read ack after second restart", a, 1'b1);
    recv_byte(d); check("R10", "read after restart", d, 8'h81 & 8'hBD);
    clock_bit(1'b1, s);
    bus_stop;
  endtask

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset;
    t_write;
    t_wrong_addr;
    t_no_start;
    t_read;
    t_irq;
    t_rstart;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL all watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule